// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking in-memory translation tables. A lookup starts by reading one word from a context table, chosen by a context-table pointer and a context number. It then descends through up to three levels of tables, reading one word per level through a word-wide memory port that uses a request/ready handshake. The walk ends on a leaf entry or on a fault. A leaf may sit at level 1 (16 MB region), level 2 (256 KB region) or level 3 (4 KB page). When the leaf's referenced bit, or its modified bit on a write, was clear, the walker writes the updated leaf back before it finishes.

When translation is switched off, the address passes straight through without any memory traffic. In that mode, with boot mode on, instruction fetches are redirected into a boot ROM window. Only one walk runs at a time. A caller raises `req_valid` for one cycle while idle, then waits for the one-cycle `done` pulse and reads the result ports, which hold their values until the next request.

The controller has four states. IDLE goes to READ on a request with translation on, or straight to DONE with translation off. READ stays in READ while it descends through directory entries. On a leaf that needs updating it goes to WBACK. On a leaf that needs no update, or on any fault, it goes to DONE. WBACK goes to DONE once the write is accepted. DONE returns to IDLE after one cycle.

Top module: `ptw_walker`

## Requirements
- R1: The context entry is read from ((ctx_ptr with bits [5:0] cleared) << 4) + (ctx_num << 2). The low six pointer bits have no effect.
- R2: Entry type is bits [1:0]: 0 invalid, 1 directory, 2 leaf, 3 reserved. A directory's next table starts at ((entry with bits [1:0] cleared) << 4). Its word index is VA[31:24], then VA[23:18], then VA[17:12]. A walk makes exactly one read per level visited.
- R3: A leaf at level 1 gives res_paddr = (entry[31:8] << 12) + VA[23:0] and res_level = 1.
- R4: A leaf at level 2 gives res_paddr = (entry[31:8] << 12) + VA[17:0] and res_level = 2.
- R5: A leaf at level 3 gives res_paddr = (entry[31:8] << 12) + VA[11:0] and res_level = 3.
- R6: The referenced bit is entry bit 5 and is set in the leaf if it was clear. The leaf is written back to its own address only when bit 5 or bit 6 changed. res_entry holds the updated leaf.
- R7: On a write lookup, the modified bit (entry bit 6) is set if it was clear. On a read lookup it is left unchanged.
- R8: res_fault = (level << 8) | (type << 2), where level is 0 for the context entry and 1 to 3 for the tables. Type is 1 for an invalid entry. Type is 4 for a reserved entry, a leaf in the context table, or a directory at level 3. On success res_fault is 0 and res_paddr is 0 on a fault.
- R9: With xlat_en low, res_paddr = VA zero-extended, res_level = 0, res_entry = 0, res_fault = 0, and no memory access takes place.
- R10: With xlat_en low, boot_mode high and req_fetch high, res_paddr = BOOT_BASE | VA[18:0]. Data accesses are not redirected, and boot_mode has no effect while xlat_en is high.
- R11: After reset, busy, done and mem_req are low. busy is high from the cycle after a request through the done pulse. done is high for exactly one cycle.
- R12: While mem_req is high and mem_rdy is low, mem_addr, mem_we and mem_wdata hold steady and mem_req stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a lookup (sampled while idle) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Lookup is for a store |
| req_fetch | input | 1 | Lookup is for an instruction fetch |
| ctx_ptr | input | 32 | Context-table pointer register value |
| ctx_num | input | 8 | Current context number |
| xlat_en | input | 1 | Translation enable |
| boot_mode | input | 1 | Redirect fetches to boot ROM while translation is off |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_rdy on a read |
| mem_rdy | input | 1 | Memory accepts or completes the access |
| res_paddr | output | 36 | Physical address |
| res_level | output | 2 | Level of the last entry read |
| res_entry | output | 32 | Last entry read, updated when a leaf |
| res_fault | output | 10 | Fault code, 0 when none |

## Verification
The in-RTL properties assume that memory raises mem_rdy for one cycle only while mem_req is high, and that mem_rdata is valid in that cycle. They also assume req_valid is only raised while busy is low. The bench memory model follows this contract and varies its latency from zero to three wait cycles. The stimulus waits for each done pulse before it issues the next request, so no request overlaps a walk. The model also records any change of address or write data during a wait and reports it, which gives an independent check on the port-holding rule.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;
    // address split
    localparam int PG_SHIFT   = 12;
    localparam int L3_BITS    = 6;
    localparam int L2_BITS    = 6;
    localparam int L1_BITS    = 8;
    localparam int VA_W       = PG_SHIFT + L3_BITS + L2_BITS + L1_BITS;
    localparam int LVL2_OFF   = PG_SHIFT + L3_BITS;
    localparam int LVL1_OFF   = LVL2_OFF + L2_BITS;
    // entry layout
    localparam int ENT_W      = 32;
    localparam int ENT_SHIFT  = 4;
    localparam int PA_W       = ENT_W + ENT_SHIFT;
    localparam int PPN_LSB    = 8;
    localparam int REF_BIT    = 5;
    localparam int MOD_BIT    = 6;
    localparam int CTX_ALIGN  = 6;
    localparam int FAULT_W    = 10;
    localparam int BOOT_W     = 19;
    localparam logic [1:0] LAST_LVL = 2'd3;

    localparam logic [1:0] ET_INVALID = 2'd0;
    localparam logic [1:0] ET_DIR     = 2'd1;
    localparam logic [1:0] ET_LEAF    = 2'd2;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_BAD     = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WBACK, ST_DONE} walk_state_t;

    function automatic logic [FAULT_W-1:0] fault_of(input logic [1:0] lvl, input logic [2:0] kind);
        return {lvl, 3'b000, kind, 2'b00};
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
`timescale 1ns/1ps
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [ENT_W-1:0]         ctx_ptr,
    input  logic [CTX_W-1:0]         ctx_num,
    input  logic [ENT_W-1:0]         entry,
    input  logic [VA_W-1:PG_SHIFT]   vpn,
    input  logic [1:0]               next_lvl,
    output logic [PA_W-1:0]          ctx_addr,
    output logic [PA_W-1:0]          tbl_addr
);
    localparam logic [ENT_W-1:0] CTX_MASK = ~((ENT_W'(1) << CTX_ALIGN) - ENT_W'(1));
    localparam logic [ENT_W-1:0] ENT_MASK = ~ENT_W'(3);

    logic [PA_W-1:0] index;

    assign ctx_addr = (PA_W'(ctx_ptr & CTX_MASK) << ENT_SHIFT) + (PA_W'(ctx_num) << 2);

    always_comb begin
        unique case (next_lvl)
            2'd1:    index = PA_W'(vpn[VA_W-1:LVL1_OFF]);
            2'd2:    index = PA_W'(vpn[LVL1_OFF-1:LVL2_OFF]);
            default: index = PA_W'(vpn[LVL2_OFF-1:PG_SHIFT]);
        endcase
    end

    assign tbl_addr = (PA_W'(entry & ENT_MASK) << ENT_SHIFT) + (index << 2);
endmodule

// File: rtl/ptw_leaf.sv
`timescale 1ns/1ps
module ptw_leaf
    import ptw_pkg::*;
(
    input  logic [ENT_W-1:0]    entry,
    input  logic [1:0]          lvl,
    input  logic [LVL1_OFF-1:0] va_off,
    input  logic                is_write,
    output logic [ENT_W-1:0]    new_entry,
    output logic                need_wb,
    output logic [PA_W-1:0]     pa
);
    logic            set_ref, set_mod;
    logic [PA_W-1:0] frame, offset;

    assign set_ref   = ~entry[REF_BIT];
    assign set_mod   = is_write & ~entry[MOD_BIT];
    assign need_wb   = set_ref | set_mod;
    assign new_entry = entry | (ENT_W'(set_ref) << REF_BIT) | (ENT_W'(set_mod) << MOD_BIT);
    assign frame     = PA_W'(entry[ENT_W-1:PPN_LSB]) << (PPN_LSB + ENT_SHIFT);

    always_comb begin
        unique case (lvl)
            2'd1:    offset = PA_W'(va_off);
            2'd2:    offset = PA_W'(va_off[LVL2_OFF-1:0]);
            default: offset = PA_W'(va_off[PG_SHIFT-1:0]);
        endcase
    end

    assign pa = frame + offset;
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int                CTX_W     = 8,
    parameter logic [PA_W-1:0]   BOOT_BASE = 36'hFF0000000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [VA_W-1:0]      req_vaddr,
    input  logic                 req_write,
    input  logic                 req_fetch,
    input  logic [ENT_W-1:0]     ctx_ptr,
    input  logic [CTX_W-1:0]     ctx_num,
    input  logic                 xlat_en,
    input  logic                 boot_mode,
    output logic                 busy,
    output logic                 done,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [PA_W-1:0]      mem_addr,
    output logic [ENT_W-1:0]     mem_wdata,
    input  logic [ENT_W-1:0]     mem_rdata,
    input  logic                 mem_rdy,
    output logic [PA_W-1:0]      res_paddr,
    output logic [1:0]           res_level,
    output logic [ENT_W-1:0]     res_entry,
    output logic [FAULT_W-1:0]   res_fault
);
    walk_state_t       state, nxt;
    logic [1:0]        lvl_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic              mem_req_q, mem_we_q;
    logic [PA_W-1:0]   mem_addr_q;
    logic [ENT_W-1:0]  mem_wdata_q;

    logic [1:0]        ent_type;
    logic [PA_W-1:0]   ctx_addr, tbl_addr, leaf_pa;
    logic [ENT_W-1:0]  new_entry;
    logic              need_wb;

    assign ent_type = mem_rdata[1:0];

    ptw_addr_gen #(.CTX_W(CTX_W)) u_addr (
        .ctx_ptr  (ctx_ptr),
        .ctx_num  (ctx_num),
        .entry    (mem_rdata),
        .vpn      (va_q[VA_W-1:PG_SHIFT]),
        .next_lvl (lvl_q + 2'd1),
        .ctx_addr (ctx_addr),
        .tbl_addr (tbl_addr)
    );

    ptw_leaf u_leaf (
        .entry     (mem_rdata),
        .lvl       (lvl_q),
        .va_off    (va_q[LVL1_OFF-1:0]),
        .is_write  (wr_q),
        .new_entry (new_entry),
        .need_wb   (need_wb),
        .pa        (leaf_pa)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (req_valid) nxt = xlat_en ? ST_READ : ST_DONE;
            ST_READ:  if (mem_rdy) begin
                unique case (ent_type)
                    ET_DIR:  nxt = (lvl_q == LAST_LVL) ? ST_DONE : ST_READ;
                    ET_LEAF: nxt = (lvl_q != 2'd0 && need_wb) ? ST_WBACK : ST_DONE;
                    default: nxt = ST_DONE;
                endcase
            end
            ST_WBACK: if (mem_rdy) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
        endcase
    end

    // outputs and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q       <= '0;
            va_q        <= '0;
            wr_q        <= 1'b0;
            mem_req_q   <= 1'b0;
            mem_we_q    <= 1'b0;
            mem_addr_q  <= '0;
            mem_wdata_q <= '0;
            res_paddr   <= '0;
            res_level   <= '0;
            res_entry   <= '0;
            res_fault   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q      <= req_vaddr;
                    wr_q      <= req_write;
                    res_fault <= '0;
                    res_entry <= '0;
                    res_level <= '0;
                    if (xlat_en) begin
                        res_paddr  <= '0;
                        mem_req_q  <= 1'b1;
                        mem_we_q   <= 1'b0;
                        mem_addr_q <= ctx_addr;
                        lvl_q      <= 2'd0;
                    end else if (req_fetch && boot_mode) begin
                        res_paddr  <= BOOT_BASE | PA_W'(req_vaddr[BOOT_W-1:0]);
                    end else begin
                        res_paddr  <= PA_W'(req_vaddr);
                    end
                end
                ST_READ: if (mem_rdy) begin
                    res_entry <= mem_rdata;
                    res_level <= lvl_q;
                    unique case (ent_type)
                        ET_DIR: begin
                            if (lvl_q == LAST_LVL) begin
                                res_fault <= fault_of(lvl_q, FT_BAD);
                                mem_req_q <= 1'b0;
                            end else begin
                                mem_addr_q <= tbl_addr;
                                lvl_q      <= lvl_q + 2'd1;
                            end
                        end
                        ET_LEAF: begin
                            if (lvl_q == 2'd0) begin
                                res_fault <= fault_of(lvl_q, FT_BAD);
                                mem_req_q <= 1'b0;
                            end else begin
                                res_paddr <= leaf_pa;
                                res_entry <= new_entry;
                                if (need_wb) begin
                                    mem_we_q    <= 1'b1;
                                    mem_wdata_q <= new_entry;
                                end else begin
                                    mem_req_q   <= 1'b0;
                                end
                            end
                        end
                        ET_INVALID: begin
                            res_fault <= fault_of(lvl_q, FT_INVALID);
                            mem_req_q <= 1'b0;
                        end
                        default: begin
                            res_fault <= fault_of(lvl_q, FT_BAD);
                            mem_req_q <= 1'b0;
                        end
                    endcase
                end
                ST_WBACK: if (mem_rdy) begin
                    mem_req_q <= 1'b0;
                    mem_we_q  <= 1'b0;
                end
                ST_DONE: ;
            endcase
        end
    end

    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_DONE);
    assign mem_req   = mem_req_q;
    assign mem_we    = mem_we_q;
    assign mem_addr  = mem_addr_q;
    assign mem_wdata = mem_wdata_q;

    // R12: port holds its request until accepted
    p_port_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R11: done lasts one cycle and lies inside busy
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R6: every write-back carries the referenced bit
    p_wb_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[REF_BIT]);

    // R8: fault codes only take the documented shapes
    p_fault_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_fault[1:0] == 2'b00 &&
                  (res_fault[7:2] == 6'd0 || res_fault[7:2] == 6'd1 || res_fault[7:2] == 6'd4)));
endmodule

// File: tb/ptw_walker_test.sv
`timescale 1ns/1ps
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic [31:0] ctx_ptr = '0;
    logic [7:0]  ctx_num = '0;
    logic        xlat_en = 1'b0;
    logic        boot_mode = 1'b0;
    logic        busy, done, mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_rdy = 1'b0;
    logic [35:0] res_paddr;
    logic [1:0]  res_level;
    logic [31:0] res_entry;
    logic [9:0]  res_fault;

    always #5 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_fetch(req_fetch), .ctx_ptr(ctx_ptr), .ctx_num(ctx_num),
        .xlat_en(xlat_en), .boot_mode(boot_mode), .busy(busy), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .res_paddr(res_paddr),
        .res_level(res_level), .res_entry(res_entry), .res_fault(res_fault)
    );

    // ---------------- memory model ----------------
    logic [31:0] mem [0:4095];
    logic [1:0]  lat = 2'd0;
    int          wait_cnt = 0;
    int          rd_cnt = 0, wr_cnt = 0, hold_err = 0;
    logic [35:0] hold_addr = '0;
    logic [31:0] hold_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rdy  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_rdy) begin
            mem_rdy  <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_req) begin
            if (wait_cnt == 0) begin
                hold_addr <= mem_addr;
                hold_data <= mem_wdata;
            end else if (mem_addr != hold_addr || (mem_we && mem_wdata != hold_data)) begin
                hold_err <= hold_err + 1;
            end
            if (wait_cnt >= int'(lat)) begin
                mem_rdy <= 1'b1;
                lat     <= lat + 2'd1;
                if (mem_we) begin
                    mem[mem_addr[13:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[13:2]];
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [31:0] va;
        logic [31:0] cp;
        logic [7:0]  cn;
        logic        wr, fe, en, bt;
        logic [35:0] pa;
        logic [1:0]  lvl;
        logic [9:0]  flt;
        logic [31:0] ent;
        logic [3:0]  rd;
        logic [3:0]  wb;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{32'h00000ABC, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h00FEEDABC, 2'd3, 10'h000, 32'h00FEED22, 4'd4, 4'd1},
        '{32'h00000123, 32'h7F, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 36'h00FEED123, 2'd3, 10'h000, 32'h00FEED62, 4'd4, 4'd1},
        '{32'h00000FFF, 32'h40, 8'd2, 1'b0, 1'b1, 1'b1, 1'b0, 36'h00FEEDFFF, 2'd3, 10'h000, 32'h00FEED62, 4'd4, 4'd0},
        '{32'h00003010, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h00BEEF010, 2'd3, 10'h000, 32'h00BEEF22, 4'd4, 4'd0},
        '{32'h00003020, 32'h40, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 36'h00BEEF020, 2'd3, 10'h000, 32'h00BEEF62, 4'd4, 4'd1},
        '{32'h01ABCDEF, 32'h40, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 36'hABCABCDEF, 2'd1, 10'h000, 32'hABC00062, 4'd2, 4'd0},
        '{32'h0007FFFF, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h12343FFFF, 2'd2, 10'h000, 32'h12340022, 4'd3, 4'd1},
        '{32'h00040005, 32'h40, 8'd2, 1'b1, 1'b0, 1'b1, 1'b0, 36'h123400005, 2'd2, 10'h000, 32'h12340062, 4'd3, 4'd1},
        '{32'h02000000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd1, 10'h104, 32'h00000000, 4'd2, 4'd0},
        '{32'h03000000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd1, 10'h110, 32'h00000003, 4'd2, 4'd0},
        '{32'h00080000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd2, 10'h210, 32'h00000003, 4'd3, 4'd0},
        '{32'h000C0000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd2, 10'h204, 32'h00000000, 4'd3, 4'd0},
        '{32'h00001000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd3, 10'h310, 32'h00000001, 4'd4, 4'd0},
        '{32'h00002000, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd3, 10'h304, 32'h00000000, 4'd4, 4'd0},
        '{32'h00000000, 32'h40, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd0, 10'h010, 32'h00000002, 4'd1, 4'd0},
        '{32'h00000000, 32'h7F, 8'd4, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd0, 10'h004, 32'h00000000, 4'd1, 4'd0},
        '{32'h00000000, 32'h40, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 36'h0,         2'd0, 10'h010, 32'h00000003, 4'd1, 4'd0},
        '{32'h89ABCDEF, 32'h40, 8'd2, 1'b0, 1'b1, 1'b0, 1'b0, 36'h089ABCDEF, 2'd0, 10'h000, 32'h00000000, 4'd0, 4'd0},
        '{32'h89ABCDEF, 32'h40, 8'd2, 1'b0, 1'b1, 1'b0, 1'b1, 36'hFF003CDEF, 2'd0, 10'h000, 32'h00000000, 4'd0, 4'd0},
        '{32'h89ABCDEF, 32'h40, 8'd2, 1'b1, 1'b0, 1'b0, 1'b1, 36'h089ABCDEF, 2'd0, 10'h000, 32'h00000000, 4'd0, 4'd0},
        '{32'h00000ABC, 32'h40, 8'd2, 1'b0, 1'b1, 1'b1, 1'b1, 36'h00FEEDABC, 2'd3, 10'h000, 32'h00FEED62, 4'd4, 4'd0}
    };

    function automatic string pa_tag(input vec_t v);
        if (!v.en) return (v.bt && v.fe) ? "R10" : "R9";
        if (v.flt != 0) return "R8";
        if (v.lvl == 2'd1) return "R3";
        if (v.lvl == 2'd2) return "R4";
        return "R5";
    endfunction

    task automatic run_vec(input vec_t v, input int k);
        int rd0, wr0, n;
        string t;
        @(negedge clk);
        req_vaddr = v.va; req_write = v.wr; req_fetch = v.fe;
        ctx_ptr = v.cp; ctx_num = v.cn; xlat_en = v.en; boot_mode = v.bt;
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk($sformatf("R11 busy after request vec %0d", k), 64'(busy), 64'd1);
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk($sformatf("R11 done seen vec %0d", k), 64'(done), 64'd1);
        t = pa_tag(v);
        chk($sformatf("%s paddr vec %0d", t, k), 64'(res_paddr), 64'(v.pa));
        chk($sformatf("%s level vec %0d", t, k), 64'(res_level), 64'(v.lvl));
        chk($sformatf("R8 fault vec %0d", k), 64'(res_fault), 64'(v.flt));
        chk($sformatf("%s entry vec %0d", v.wr ? "R7" : "R6", k), 64'(res_entry), 64'(v.ent));
        chk($sformatf("%s reads vec %0d", (v.en && v.lvl == 2'd0) ? "R1" : (v.en ? "R2" : "R9"), k),
            64'(rd_cnt - rd0), 64'(v.rd));
        chk($sformatf("%s writebacks vec %0d", v.wr ? "R7" : "R6", k), 64'(wr_cnt - wr0), 64'(v.wb));
        @(negedge clk);
        chk($sformatf("R11 done single cycle vec %0d", k), 64'(done), 64'd0);
        chk($sformatf("R11 busy cleared vec %0d", k), 64'(busy), 64'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
        mem[12'h408 >> 2]  = 32'h00000081;   // ctx 2 -> level-1 table at 0x800
        mem[12'h40C >> 2]  = 32'h00000002;   // ctx 3: leaf in context table
        mem[12'h410 >> 2]  = 32'h00000000;   // ctx 4: invalid
        mem[12'h414 >> 2]  = 32'h00000003;   // ctx 5: reserved
        mem[12'h800 >> 2]  = 32'h000000C1;   // L1[0] -> L2 table at 0xC00
        mem[12'h804 >> 2]  = 32'hABC00062;   // L1[1] 16 MB leaf, R and M set
        mem[12'h808 >> 2]  = 32'h00000000;   // L1[2] invalid
        mem[12'h80C >> 2]  = 32'h00000003;   // L1[3] reserved
        mem[12'hC00 >> 2]  = 32'h00000101;   // L2[0] -> L3 table at 0x1000
        mem[12'hC04 >> 2]  = 32'h12340002;   // L2[1] 256 KB leaf, clean
        mem[12'hC08 >> 2]  = 32'h00000003;   // L2[2] reserved
        mem[12'hC0C >> 2]  = 32'h00000000;   // L2[3] invalid
        mem[13'h1000 >> 2] = 32'h00FEED02;   // L3[0] page, clean
        mem[13'h1004 >> 2] = 32'h00000001;   // L3[1] directory at last level
        mem[13'h1008 >> 2] = 32'h00000000;   // L3[2] invalid
        mem[13'h100C >> 2] = 32'h00BEEF22;   // L3[3] page, referenced

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset busy", 64'(busy), 64'd0);
        chk("R11 reset done", 64'(done), 64'd0);
        chk("R11 reset mem_req", 64'(mem_req), 64'd0);
        chk("R8 reset fault", 64'(res_fault), 64'd0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);

        // reset in the middle of a walk
        @(negedge clk);
        req_vaddr = 32'h01000010; req_write = 1'b0; req_fetch = 1'b0;
        ctx_ptr = 32'h40; ctx_num = 8'd2; xlat_en = 1'b1; boot_mode = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 mid-walk reset busy", 64'(busy), 64'd0);
        chk("R11 mid-walk reset mem_req", 64'(mem_req), 64'd0);
        chk("R11 mid-walk reset done", 64'(done), 64'd0);
        rst_n = 1'b1;
        run_vec('{32'h01000010, 32'h40, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 36'hABC000010, 2'd1,
                  10'h000, 32'hABC00062, 4'd2, 4'd0}, 99);

        chk("R12 port held during waits", 64'(hold_err), 64'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=hung expected=finished");
        finish_run();
    end
endmodule